// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block sits between a processor load/store port and a slower main-memory port. Each CPU address is divided into three parts. The lowest bits pick a byte within a word. The next bits pick a word within a line. The bits above those pick the line index, and whatever remains above the index is the tag. Every line keeps a valid flag, a dirty flag, a tag and a block of several words. A load whose index and tag match a valid line is answered in the same cycle. On a load miss the controller reads the whole line from memory one word at a time, installs it together with its tag, and then answers the load.

Memory latency can vary. Each word crosses the memory port under a request that stays asserted and stable until memory pulses its ready line. Words move in ascending order, starting at word zero of the line.

The parameter `WRITE_BACK` decides how stores behave:

- **Write-back mode.** A store stays in the cache and marks the line dirty. A store miss first fetches the line. Before a dirty line is replaced, its old contents are written back to memory.
- **Write-through mode.** Every store goes to memory as a single word. A store that misses does not bring the line into the cache.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid and not dirty. While no request is pending, `mem_req` and `cpu_ready` stay low.
- R2: The CPU address is decoded as follows, from the bottom up:
  - byte-in-word: `$clog2(WORD_W/8)` bits;
  - word-in-line: `$clog2(LINE_WORDS)` bits;
  - line index: `$clog2(LINES)` bits;
  - tag: the remaining upper bits.

  Two addresses that differ only in tag bits compete for the same line.
- R3: A load that hits raises `cpu_ready` in the cycle the request is presented, returns the stored word on `cpu_rdata`, and causes no memory traffic.
- R4: A line fill reads every word of the line, in ascending order from word 0. Exactly one word moves per `mem_ready` pulse. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until that pulse.
- R5: A line that is not valid never hits, even when its stored tag bits equal the request tag.
- R6: `cpu_ready` stays low for every cycle in which a memory transfer for the current request is still outstanding.
- R7: In write-back mode, a store that hits writes only the cache and marks the line dirty. Memory is not written.
- R8: In write-back mode, a miss on a dirty line first writes the whole old line back to memory (word 0 first, ascending), and only then fetches the new line.
- R9: In write-back mode, a store that misses fetches the line and then writes the store word into it. A later load returns the stored word, and the other words of the line come from memory.
- R10: In write-through mode, every store writes exactly one word to memory. The store completes on that word's `mem_ready`. A store hit also updates the cached word.
- R11: In write-through mode, a store that misses performs no line fill. A later load of that address misses and reads the line from memory.
- R12: In write-through mode, replacing a line never writes memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU request; held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address (word aligned) |
| cpu_wdata | input | WORD_W | Store data |
| cpu_rdata | output | WORD_W | Load data, valid when `cpu_ready` is high for a load |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Byte address of the word being transferred |
| mem_wdata | output | WORD_W | Write data to memory |
| mem_rdata | input | WORD_W | Read data from memory, valid with `mem_ready` |
| mem_ready | input | 1 | One pulse per completed word transfer |

## Verification
The bench builds two instances side by side, each with the default geometry: 16-bit addresses, 32-bit words, two-word (8-byte) lines and four lines. One instance runs in write-back mode and the other in write-through mode, so both store policies run against the same directed address patterns.

With only four lines, a tag change in bit 5 forces a conflict on a chosen index. This brings the following within reach in a few accesses:
- dirty evictions and clean replacements;
- hits on an invalid line whose stored tag happens to match;
- store misses that do or do not allocate.

The memory model's latency depends on the word address, so fills and write-backs see uneven delays between words.

// File: rtl/cache_pkg.sv
// Package: shared types for the direct-mapped cache.
// Assumes: nothing beyond IEEE 1800-2017.
package cache_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // lookup and answer hits
        ST_EVICT = 2'd1,   // write dirty victim line back to memory
        ST_FILL  = 2'd2,   // read the requested line from memory
        ST_THRU  = 2'd3    // write-through single word store
    } cache_state_e;

endpackage

// File: rtl/cache_addr_split.sv
// Module: cache_addr_split
// Splits a CPU byte address into tag, line index and word-in-line select.
// Assumes: accesses are word aligned; the byte-in-word bits are ignored.
module cache_addr_split #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 2,
    parameter int WSEL_W = 1,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WSEL_W-1:0] wsel
);

    logic [BYTE_W-1:0] byte_unused;

    // Field extraction from the low end upwards.
    always_comb begin
        byte_unused = addr[BYTE_W-1:0];
        wsel        = addr[BYTE_W +: WSEL_W];
        idx         = addr[BYTE_W+WSEL_W +: IDX_W];
        tag         = addr[ADDR_W-1 -: TAG_W];
    end

endmodule

// File: rtl/cache_lines.sv
// Module: cache_lines
// Line storage: per-line valid, dirty and tag, plus a block of data words.
// Provides two read ports on the addressed line (CPU word and transfer word).
// Assumes: one write per cycle; an install sets valid and clears dirty.
module cache_lines #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 2,
    parameter int LINES      = 4,
    parameter int TAG_W      = 11,
    localparam int IDX_W     = $clog2(LINES),
    localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] cpu_wsel,
    input  logic [WSEL_W-1:0] xfer_wsel,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              set_dirty,
    input  logic              install_en,
    input  logic [TAG_W-1:0]  install_tag,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [TAG_W-1:0]  line_tag,
    output logic [WORD_W-1:0] cpu_word,
    output logic [WORD_W-1:0] xfer_word
);

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [WORD_W-1:0] data_q [LINES][LINE_WORDS];

    // Status flags: cleared by reset, set on install or store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (set_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag and data arrays: no reset, qualified by the valid flags.
    always_ff @(posedge clk) begin
        if (install_en) begin
            tag_q[idx] <= install_tag;
        end
        if (wr_en) begin
            data_q[idx][wr_wsel] <= wr_data;
        end
    end

    // Read ports on the addressed line.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
        cpu_word   = data_q[idx][cpu_wsel];
        xfer_word  = data_q[idx][xfer_wsel];
    end

    // R1: reset leaves every line invalid and clean.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0 && dirty_q == '0));

    // R7: a store hit leaves the line marked dirty.
    p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_dirty && !install_en) |=> dirty_q[$past(idx)]);

endmodule

// File: rtl/cache_ctrl.sv
// Module: cache_ctrl
// Sequencer: hit detection, CPU handshake, victim write-back, line fill and
// write-through stores. WRITE_BACK selects the store policy.
// Assumes: the CPU holds its request fields until cpu_ready; memory answers
// each held request with a single mem_ready pulse.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int WRITE_BACK = 1,
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 2,
    parameter int BYTE_W     = 2,
    parameter int WSEL_W     = 1,
    parameter int IDX_W      = 2,
    parameter int TAG_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [WSEL_W-1:0] cpu_wsel,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [WORD_W-1:0] xfer_word,
    output logic [WSEL_W-1:0] xfer_wsel,
    output logic              wr_en,
    output logic [WSEL_W-1:0] wr_wsel,
    output logic [WORD_W-1:0] wr_data,
    output logic              set_dirty,
    output logic              install_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    localparam logic              WB_MODE   = (WRITE_BACK != 0);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);
    localparam logic [BYTE_W-1:0] NO_BYTE   = '0;

    cache_state_e      state_q, state_d;
    logic [WSEL_W-1:0] cnt_q, cnt_d;
    logic              hit;
    logic              last;

    // Hit requires a valid line and matching tag.
    always_comb begin
        hit  = line_valid && (line_tag == cpu_tag);
        last = (cnt_q == LAST_WORD);
    end

    // Next-state, handshake and array control decode.
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        cpu_ready  = 1'b0;
        wr_en      = 1'b0;
        wr_wsel    = cpu_wsel;
        wr_data    = cpu_wdata;
        set_dirty  = 1'b0;
        install_en = 1'b0;
        xfer_wsel  = cnt_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        if (!cpu_we) begin
                            cpu_ready = 1'b1;
                        end else if (WB_MODE) begin
                            wr_en     = 1'b1;
                            set_dirty = 1'b1;
                            cpu_ready = 1'b1;
                        end else begin
                            state_d = ST_THRU;
                        end
                    end else if (cpu_we && !WB_MODE) begin
                        state_d = ST_THRU;
                    end else if (WB_MODE && line_valid && line_dirty) begin
                        state_d = ST_EVICT;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_FILL;
                        cnt_d   = '0;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {line_tag, cpu_idx, cnt_q, NO_BYTE};
                mem_wdata = xfer_word;
                if (mem_ready) begin
                    cnt_d = cnt_q + WSEL_W'(1);
                    if (last) begin
                        state_d = ST_FILL;
                        cnt_d   = '0;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {cpu_tag, cpu_idx, cnt_q, NO_BYTE};
                if (mem_ready) begin
                    wr_en   = 1'b1;
                    wr_wsel = cnt_q;
                    wr_data = mem_rdata;
                    cnt_d   = cnt_q + WSEL_W'(1);
                    if (last) begin
                        install_en = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            ST_THRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cpu_tag, cpu_idx, cpu_wsel, NO_BYTE};
                mem_wdata = cpu_wdata;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    wr_en     = hit;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and word counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R6: no answer to the CPU while a memory word is still outstanding.
    p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |-> !cpu_ready);

    // R4: an unanswered memory request is held unchanged.
    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R4: line transfers step through the words in ascending order.
    p_seq_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FILL || state_q == ST_EVICT) && mem_ready && !last)
        |=> (mem_req && mem_addr[BYTE_W +: WSEL_W]
             == $past(mem_addr[BYTE_W +: WSEL_W]) + WSEL_W'(1)));

    // R8: the last write-back word is followed by a line read.
    p_evict_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_ready && last) |=> (mem_req && !mem_we));

    // R5: an invalid line never answers a request from the lookup state.
    p_invalid_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !line_valid) |-> !cpu_ready);

    generate
        if (WRITE_BACK == 0) begin : g_wt_checks
            // R11: a write-through store never starts a memory read.
            p_wt_no_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_IDLE && cpu_req && cpu_we) |=> !(mem_req && !mem_we));
        end
    endgenerate

endmodule

// File: rtl/dm_cache.sv
// Module: dm_cache (top)
// Direct-mapped cache between a CPU load/store port and a memory port with a
// request/ready word handshake. WRITE_BACK=1 selects write-back with store
// allocation; WRITE_BACK=0 selects write-through without store allocation.
// Assumes: word-aligned accesses, LINE_WORDS and LINES powers of two, LINE_WORDS >= 2.
module dm_cache #(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 2,
    parameter int LINES      = 4,
    parameter int WRITE_BACK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W;

    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  cpu_idx;
    logic [WSEL_W-1:0] cpu_wsel;
    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [WORD_W-1:0] xfer_word;
    logic [WSEL_W-1:0] xfer_wsel;
    logic              wr_en, set_dirty, install_en;
    logic [WSEL_W-1:0] wr_wsel;
    logic [WORD_W-1:0] wr_data;

    cache_addr_split #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .WSEL_W (WSEL_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_split (
        .addr (cpu_addr),
        .tag  (cpu_tag),
        .idx  (cpu_idx),
        .wsel (cpu_wsel)
    );

    cache_lines #(
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS),
        .LINES      (LINES),
        .TAG_W      (TAG_W)
    ) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (cpu_idx),
        .cpu_wsel    (cpu_wsel),
        .xfer_wsel   (xfer_wsel),
        .wr_en       (wr_en),
        .wr_wsel     (wr_wsel),
        .wr_data     (wr_data),
        .set_dirty   (set_dirty),
        .install_en  (install_en),
        .install_tag (cpu_tag),
        .line_valid  (line_valid),
        .line_dirty  (line_dirty),
        .line_tag    (line_tag),
        .cpu_word    (cpu_rdata),
        .xfer_word   (xfer_word)
    );

    cache_ctrl #(
        .WRITE_BACK (WRITE_BACK),
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS),
        .BYTE_W     (BYTE_W),
        .WSEL_W     (WSEL_W),
        .IDX_W      (IDX_W),
        .TAG_W      (TAG_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_tag    (cpu_tag),
        .cpu_idx    (cpu_idx),
        .cpu_wsel   (cpu_wsel),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .xfer_word  (xfer_word),
        .xfer_wsel  (xfer_wsel),
        .wr_en      (wr_en),
        .wr_wsel    (wr_wsel),
        .wr_data    (wr_data),
        .set_dirty  (set_dirty),
        .install_en (install_en),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready)
    );

endmodule

// File: tb/dm_cache_tb.sv
// Word memory model with address-dependent latency and a transfer log.
module cache_mem_model #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 32,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              ready,
    output logic [WORD_W-1:0] rdata
);
    localparam int BW = $clog2(WORD_W / 8);
    localparam int DW = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    int rd_cnt, wr_cnt, wait_cnt;
    int rd_log [8];
    int wr_log [8];

    initial begin
        ready = 1'b0;
        rdata = '0;
    end

    // Respond at the falling edge so the cache samples settled values.
    always @(negedge clk) begin
        int w;
        w = int'(addr[BW +: DW]);
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] = 32'hC0DE_0000 + i;
            ready = 1'b0; rd_cnt = 0; wr_cnt = 0; wait_cnt = 0;
        end else if (ready) begin
            ready = 1'b0;
            wait_cnt = 0;
        end else if (req) begin
            if (wait_cnt >= (w % 3)) begin
                ready = 1'b1;
                wait_cnt = 0;
                if (we) begin
                    mem[w] = wdata;
                    wr_log[wr_cnt % 8] = w;
                    wr_cnt++;
                end else begin
                    rdata = mem[w];
                    rd_log[rd_cnt % 8] = w;
                    rd_cnt++;
                end
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end
endmodule

module dm_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, sel = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;

    logic        req_a, ready_a, mreq_a, mwe_a, mrdy_a;
    logic        req_b, ready_b, mreq_b, mwe_b, mrdy_b;
    logic [31:0] rdata_a, rdata_b, mwd_a, mwd_b, mrd_a, mrd_b;
    logic [15:0] maddr_a, maddr_b;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign req_a = req & ~sel;
    assign req_b = req & sel;

    dm_cache #(.WRITE_BACK(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(req_a), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_rdata(rdata_a), .cpu_ready(ready_a),
        .mem_req(mreq_a), .mem_we(mwe_a), .mem_addr(maddr_a), .mem_wdata(mwd_a),
        .mem_rdata(mrd_a), .mem_ready(mrdy_a));

    dm_cache #(.WRITE_BACK(0)) u_dut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(req_b), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_rdata(rdata_b), .cpu_ready(ready_b),
        .mem_req(mreq_b), .mem_we(mwe_b), .mem_addr(maddr_b), .mem_wdata(mwd_b),
        .mem_rdata(mrd_b), .mem_ready(mrdy_b));

    cache_mem_model u_mem_wb (
        .clk(clk), .rst_n(rst_n), .req(mreq_a), .we(mwe_a), .addr(maddr_a),
        .wdata(mwd_a), .ready(mrdy_a), .rdata(mrd_a));

    cache_mem_model u_mem_wt (
        .clk(clk), .rst_n(rst_n), .req(mreq_b), .we(mwe_b), .addr(maddr_b),
        .wdata(mwd_b), .ready(mrdy_b), .rdata(mrd_b));

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // One CPU access; returns data and the number of stalled cycles.
    task automatic access(input bit s, input bit w, input logic [15:0] a,
                          input logic [31:0] d, output logic [31:0] r, output int waits);
        @(negedge clk);
        sel = s; we = w; addr = a; wdata = d; req = 1'b1; waits = 0;
        #1;
        while (!(s ? ready_b : ready_a) && waits < 400) begin
            @(negedge clk); #1; waits++;
        end
        r = s ? rdata_b : rdata_a;
        @(negedge clk);
        req = 1'b0;
    endtask

    function automatic int rd_wb(); return u_mem_wb.rd_cnt; endfunction
    function automatic int wr_wb(); return u_mem_wb.wr_cnt; endfunction
    function automatic int rd_wt(); return u_mem_wt.rd_cnt; endfunction
    function automatic int wr_wt(); return u_mem_wt.wr_cnt; endfunction

    task automatic t_reset();
        #1;
        check("R1 cpu_ready after reset", 32'(ready_a), 32'd0);
        check("R1 mem_req after reset (wb)", 32'(mreq_a), 32'd0);
        check("R1 mem_req after reset (wt)", 32'(mreq_b), 32'd0);
    endtask

    task automatic t_invalid_line();
        logic [31:0] r; int wt, r0;
        r0 = rd_wb();
        access(0, 0, 16'h0000, 0, r, wt);   // stored tag bits may equal 0
        check("R5 invalid line fetched", 32'(rd_wb() - r0), 32'd2);
        check("R5 load data", r, 32'hC0DE_0000);
        check("R6 stalled during fill", 32'(wt > 0), 32'd1);
    endtask

    task automatic t_load_miss_hit();
        logic [31:0] r; int wt, r0;
        r0 = rd_wb();
        access(0, 0, 16'h0014, 0, r, wt);
        check("R4 fill word count", 32'(rd_wb() - r0), 32'd2);
        check("R4 first fill word", 32'(u_mem_wb.rd_log[r0 % 8]), 32'd4);
        check("R4 second fill word", 32'(u_mem_wb.rd_log[(r0 + 1) % 8]), 32'd5);
        check("R4 load miss data", r, 32'hC0DE_0005);
        r0 = rd_wb();
        access(0, 0, 16'h0010, 0, r, wt);
        check("R3 hit no wait", 32'(wt), 32'd0);
        check("R3 hit no traffic", 32'(rd_wb() - r0), 32'd0);
        check("R3 hit data", r, 32'hC0DE_0004);
    endtask

    task automatic t_wb_store_hit();
        logic [31:0] r; int wt, w0;
        w0 = wr_wb();
        access(0, 1, 16'h0010, 32'h1234_5678, r, wt);
        check("R7 store hit no wait", 32'(wt), 32'd0);
        check("R7 store hit no memory write", 32'(wr_wb() - w0), 32'd0);
        check("R7 memory untouched", u_mem_wb.mem[4], 32'hC0DE_0004);
        access(0, 0, 16'h0010, 0, r, wt);
        check("R7 cache holds store", r, 32'h1234_5678);
    endtask

    task automatic t_wb_evict();
        logic [31:0] r; int wt, w0, r0;
        w0 = wr_wb(); r0 = rd_wb();
        access(0, 0, 16'h0030, 0, r, wt);   // same index, tag bit 5 differs
        check("R8 write-back count", 32'(wr_wb() - w0), 32'd2);
        check("R8 write-back first word", 32'(u_mem_wb.wr_log[w0 % 8]), 32'd4);
        check("R8 write-back second word", 32'(u_mem_wb.wr_log[(w0 + 1) % 8]), 32'd5);
        check("R8 dirty word in memory", u_mem_wb.mem[4], 32'h1234_5678);
        check("R2 conflict fill count", 32'(rd_wb() - r0), 32'd2);
        check("R2 conflict load data", r, 32'hC0DE_000C);
        w0 = wr_wb(); r0 = rd_wb();
        access(0, 0, 16'h0010, 0, r, wt);   // clean line replaced
        check("R8 clean replace no write", 32'(wr_wb() - w0), 32'd0);
        check("R2 refill count", 32'(rd_wb() - r0), 32'd2);
        check("R8 written-back data returns", r, 32'h1234_5678);
    endtask

    task automatic t_wb_store_miss();
        logic [31:0] r; int wt, w0, r0;
        w0 = wr_wb(); r0 = rd_wb();
        access(0, 1, 16'h0048, 32'hAAAA_5555, r, wt);
        check("R9 store miss allocates", 32'(rd_wb() - r0), 32'd2);
        check("R9 store miss no write", 32'(wr_wb() - w0), 32'd0);
        check("R6 store miss stalls", 32'(wt > 0), 32'd1);
        r0 = rd_wb();
        access(0, 0, 16'h0048, 0, r, wt);
        check("R9 stored word", r, 32'hAAAA_5555);
        access(0, 0, 16'h004C, 0, r, wt);
        check("R9 neighbour word", r, 32'hC0DE_0013);
        check("R9 reads after allocate", 32'(rd_wb() - r0), 32'd0);
        check("R9 memory untouched", u_mem_wb.mem[18], 32'hC0DE_0012);
    endtask

    task automatic t_wt_store_hit();
        logic [31:0] r; int wt, w0, r0;
        access(1, 0, 16'h0020, 0, r, wt);
        check("R4 wt load miss data", r, 32'hC0DE_0008);
        w0 = wr_wt(); r0 = rd_wt();
        access(1, 1, 16'h0024, 32'hBEEF_0001, r, wt);
        check("R10 one word written", 32'(wr_wt() - w0), 32'd1);
        check("R10 no read", 32'(rd_wt() - r0), 32'd0);
        check("R10 memory updated", u_mem_wt.mem[9], 32'hBEEF_0001);
        check("R6 store waits for memory", 32'(wt > 0), 32'd1);
        r0 = rd_wt();
        access(1, 0, 16'h0024, 0, r, wt);
        check("R10 cache updated", r, 32'hBEEF_0001);
        check("R10 hit after store", 32'(rd_wt() - r0), 32'd0);
    endtask

    task automatic t_wt_store_miss();
        logic [31:0] r; int wt, w0, r0;
        w0 = wr_wt(); r0 = rd_wt();
        access(1, 1, 16'h0058, 32'h0000_5A5A, r, wt);
        check("R11 store miss write count", 32'(wr_wt() - w0), 32'd1);
        check("R11 store miss no fill", 32'(rd_wt() - r0), 32'd0);
        r0 = rd_wt();
        access(1, 0, 16'h0058, 0, r, wt);
        check("R11 later load misses", 32'(rd_wt() - r0), 32'd2);
        check("R11 later load data", r, 32'h0000_5A5A);
    endtask

    task automatic t_wt_evict();
        logic [31:0] r; int wt, w0, r0;
        w0 = wr_wt(); r0 = rd_wt();
        access(1, 0, 16'h0000, 0, r, wt);   // replaces the stored-to line
        check("R12 no write on replace", 32'(wr_wt() - w0), 32'd0);
        check("R12 fill on replace", 32'(rd_wt() - r0), 32'd2);
        check("R12 load data", r, 32'hC0DE_0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_invalid_line();
        t_load_miss_hit();
        t_wb_store_hit();
        t_wb_evict();
        t_wb_store_miss();
        t_wt_store_hit();
        t_wt_store_miss();
        t_wt_evict();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule